// File: doc/BRIEF.md
# Sequential Display Memory Loader

This block takes display contents from a narrow parallel bus that carries both control words and display data. A strobe with the mode select high delivers a control word. That word sets three display flags: decode enable, decode type and shutdown. It may also arm the loader for a burst. Once armed, each later strobe with the mode select low stores one data word. The words go into an eight-entry digit memory in fixed order, starting at digit 0.

When the last digit has been written, the loader locks. Further data strobes have no effect until a new arming control word arrives. No single digit can be rewritten on its own: every load refreshes the whole memory in order. The bus, the mode select and the active-low write strobe come from outside the clock domain. They are brought in through a two-stage synchroniser, and the strobe's falling edge is detected in the system clock domain. The stored digits and the flags appear as plain outputs for a downstream scan stage.

Top module: `seq_digit_loader`

## Requirements
- R1: While reset is high, and after it falls, every digit output is 0, all three flags are 0 and the loader is unarmed.
- R2: A falling edge of the write strobe with the mode select high accepts a control word. Bit 0 sets decode enable, bit 1 sets decode type and bit 2 sets shutdown.
- R3: A control word with bit 3 set arms the loader. Each later falling edge with the mode select low stores the bus value into digits 0, 1, …, 7 in that order.
- R4: After the eighth data word of a burst, further data strobes leave every digit unchanged until the loader is armed again.
- R5: Re-arming restarts the burst at digit 0. Digits not yet reached by the new burst keep their earlier values.
- R6: A control word with bit 3 clear updates only the flags and leaves the memory and the armed state unchanged. Any accepted control word returns the next write position to digit 0.
- R7: Data strobes arriving while the loader is unarmed leave every digit unchanged.
- R8: A strobe changes the outputs on the third rising clock edge after the write strobe falls, and not earlier.
- R9: Holding the write strobe low for many cycles counts as a single strobe.
- R10: Data strobes never change the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_i | input | DATA_W | Shared control and data bus |
| mode_i | input | 1 | 1 selects a control word, 0 selects display data |
| wr_n_i | input | 1 | Active-low write strobe, asynchronous |
| digits_o | output | DIGITS*DATA_W | Stored digits, digit k at bits k*DATA_W upward |
| decode_en_o | output | 1 | Latched decode enable flag |
| decode_type_o | output | 1 | Latched decode type flag |
| shutdown_o | output | 1 | Latched shutdown flag |

## Verification
A wrong address counter shows up at the outputs within three clock edges of the next data strobe, because a word lands in an unexpected digit. Its effect stays visible for the rest of the burst. A wrong armed state shows up on the first strobe after the eighth write, or on the first strobe after a non-arming control word, because a digit changes when it should not. A flaw in edge detection shows up as extra or missing writes while the strobe is held low. The latency of the synchroniser is checked edge by edge around a single strobe.

// File: rtl/seq_loader_pkg.sv
package seq_loader_pkg;

   // control word bit positions
   localparam int CW_DEC_EN   = 0;
   localparam int CW_DEC_TYPE = 1;
   localparam int CW_SHUT     = 2;
   localparam int CW_ARM      = 3;
   localparam int CW_BITS     = 4;

   typedef struct packed {
      logic dec_en;
      logic dec_type;
      logic shut;
   } disp_flags_t;

endpackage

// File: rtl/loader_sync.sv
module loader_sync #(
   parameter int             W       = 6,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("loader_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("loader_sync: W must be positive");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= RST_VAL;
            else     stage_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= RST_VAL;
            else     stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/loader_ctrl.sv
module loader_ctrl
   import seq_loader_pkg::*;
#(
   parameter int DATA_W = 4,
   parameter int DIGITS = 8,
   localparam int ADDR_W = $clog2(DIGITS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_s,
   input  logic              wr_n_s,
   input  logic [DATA_W-1:0] word_s,
   output disp_flags_t       flags_o,
   output logic              armed_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              cw_take_o,
   output logic              dw_take_o
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DIGITS - 1);

   if (DATA_W < CW_BITS) begin : g_bad_width
      $error("loader_ctrl: DATA_W must hold a full control word");
   end
   if (DIGITS < 2) begin : g_bad_depth
      $error("loader_ctrl: DIGITS must be at least 2");
   end

   logic        wr_q;
   logic        strobe_fall;
   disp_flags_t flags_q;
   logic        armed_q;
   logic [ADDR_W-1:0] addr_q;

   // edge register: remembers last synchronised strobe level
   always_ff @(posedge clk) begin
      if (rst) wr_q <= 1'b1;
      else     wr_q <= wr_n_s;
   end

   assign strobe_fall = wr_q & ~wr_n_s;
   assign cw_take_o   = strobe_fall & mode_s;
   assign dw_take_o   = strobe_fall & ~mode_s & armed_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         flags_q <= '0;
      end else if (cw_take_o) begin
         flags_q.dec_en   <= word_s[CW_DEC_EN];
         flags_q.dec_type <= word_s[CW_DEC_TYPE];
         flags_q.shut     <= word_s[CW_SHUT];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q <= 1'b0;
         addr_q  <= '0;
      end else if (cw_take_o) begin
         addr_q <= '0;
         if (word_s[CW_ARM]) armed_q <= 1'b1;
      end else if (dw_take_o) begin
         if (addr_q == LAST_ADDR) begin
            armed_q <= 1'b0;
            addr_q  <= '0;
         end else begin
            addr_q <= addr_q + 1'b1;
         end
      end
   end

   assign flags_o = flags_q;
   assign armed_o = armed_q;
   assign addr_o  = addr_q;

endmodule

// File: rtl/loader_digit_mem.sv
module loader_digit_mem #(
   parameter int DATA_W = 4,
   parameter int DIGITS = 8,
   localparam int ADDR_W = $clog2(DIGITS)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     we_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [DATA_W-1:0]        din_i,
   output logic [DIGITS*DATA_W-1:0] digits_o
);

   if (DIGITS > 256) begin : g_bad_depth
      $error("loader_digit_mem: DIGITS too large for register storage");
   end

   for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      logic [DATA_W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (rst)                                cell_q <= '0;
         else if (we_i && addr_i == ADDR_W'(g))  cell_q <= din_i;
      end
      assign digits_o[g*DATA_W +: DATA_W] = cell_q;
   end

endmodule

// File: rtl/seq_digit_loader.sv
module seq_digit_loader
   import seq_loader_pkg::*;
#(
   parameter int DATA_W      = 4,
   parameter int DIGITS      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [DATA_W-1:0]        bus_i,
   input  logic                     mode_i,
   input  logic                     wr_n_i,
   output logic [DIGITS*DATA_W-1:0] digits_o,
   output logic                     decode_en_o,
   output logic                     decode_type_o,
   output logic                     shutdown_o
);

   localparam int ADDR_W = $clog2(DIGITS);
   localparam int SYNC_W = DATA_W + 2;
   localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, 1'b0, {DATA_W{1'b0}}};

   logic [SYNC_W-1:0] sync_q;
   logic              wr_n_s;
   logic              mode_s;
   logic [DATA_W-1:0] word_s;
   disp_flags_t       flags;
   logic              armed;
   logic [ADDR_W-1:0] addr;
   logic              cw_take;
   logic              dw_take;

   // strobe, mode and bus share one synchroniser so they stay aligned
   loader_sync #(
      .W       (SYNC_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i ({wr_n_i, mode_i, bus_i}),
      .q_o (sync_q)
   );

   assign wr_n_s = sync_q[SYNC_W-1];
   assign mode_s = sync_q[SYNC_W-2];
   assign word_s = sync_q[DATA_W-1:0];

   loader_ctrl #(
      .DATA_W (DATA_W),
      .DIGITS (DIGITS)
   ) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .mode_s    (mode_s),
      .wr_n_s    (wr_n_s),
      .word_s    (word_s),
      .flags_o   (flags),
      .armed_o   (armed),
      .addr_o    (addr),
      .cw_take_o (cw_take),
      .dw_take_o (dw_take)
   );

   loader_digit_mem #(
      .DATA_W (DATA_W),
      .DIGITS (DIGITS)
   ) u_mem (
      .clk      (clk),
      .rst      (rst),
      .we_i     (dw_take),
      .addr_i   (addr),
      .din_i    (word_s),
      .digits_o (digits_o)
   );

   assign decode_en_o   = flags.dec_en;
   assign decode_type_o = flags.dec_type;
   assign shutdown_o    = flags.shut;

endmodule

// File: rtl/loader_checker.sv
module loader_checker #(
   parameter int DATA_W = 4,
   parameter int DIGITS = 8,
   localparam int ADDR_W = $clog2(DIGITS)
) (
   input logic                     clk,
   input logic                     rst,
   input logic [DIGITS*DATA_W-1:0] digits,
   input logic [2:0]               flags,
   input logic                     armed,
   input logic [ADDR_W-1:0]        addr,
   input logic                     cw_take,
   input logic                     dw_take,
   input logic                     arm_bit
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DIGITS - 1);

   // R1: reset clears memory, flags and armed state
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (digits == '0 && flags == 3'b000 && !armed));

   // R10: flags move only after an accepted control word
   p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !cw_take |=> $stable(flags));

   // R4 / R7: memory moves only on a data write
   p_mem_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !dw_take |=> $stable(digits));

   // R6: every control word restarts at digit 0
   p_addr_zero_r6: assert property (@(posedge clk) disable iff (rst)
      cw_take |=> addr == '0);

   // R3: write position advances by one per data word
   p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
      (dw_take && addr != LAST_ADDR) |=> addr == $past(addr) + 1'b1);

   // R4: the last digit locks the loader
   p_lock_r4: assert property (@(posedge clk) disable iff (rst)
      (dw_take && addr == LAST_ADDR) |=> !armed);

   // R6: a non-arming control word keeps the armed state
   p_arm_keep_r6: assert property (@(posedge clk) disable iff (rst)
      (cw_take && !arm_bit) |=> armed == $past(armed));

   // R9: one strobe edge gives at most one write
   p_single_write_r9: assert property (@(posedge clk) disable iff (rst)
      dw_take |=> !dw_take);

endmodule

bind seq_digit_loader loader_checker #(
   .DATA_W (DATA_W),
   .DIGITS (DIGITS)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .digits  (digits_o),
   .flags   ({decode_en_o, decode_type_o, shutdown_o}),
   .armed   (armed),
   .addr    (addr),
   .cw_take (cw_take),
   .dw_take (dw_take),
   .arm_bit (word_s[3])
);

// File: tb/tb_seq_digit_loader.sv
module tb_seq_digit_loader;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 4;
   localparam int ND = 8;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [DW-1:0]   bus = '0;
   logic            mode = 1'b0;
   logic            wr_n = 1'b1;
   logic [ND*DW-1:0] digits;
   logic            dec_en, dec_type, shut;

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] exp_mem [ND];
   logic [2:0]    exp_flags;
   logic          exp_armed;
   int            exp_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   seq_digit_loader #(.DATA_W(DW), .DIGITS(ND), .SYNC_STAGES(2)) dut (
      .clk           (clk),
      .rst           (rst),
      .bus_i         (bus),
      .mode_i        (mode),
      .wr_n_i        (wr_n),
      .digits_o      (digits),
      .decode_en_o   (dec_en),
      .decode_type_o (dec_type),
      .shutdown_o    (shut)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_all(string req);
      for (int k = 0; k < ND; k++)
         chk(req, $sformatf("digit%0d", k), int'(digits[k*DW +: DW]), int'(exp_mem[k]));
      chk(req, "flags", int'({shut, dec_type, dec_en}), int'(exp_flags));
   endtask

   // model of one strobe, taken from the requirements
   task automatic model(input logic m, input logic [DW-1:0] w);
      if (m) begin
         exp_flags = w[2:0];
         exp_addr  = 0;
         if (w[3]) exp_armed = 1'b1;
      end else if (exp_armed) begin
         exp_mem[exp_addr] = w;
         if (exp_addr == ND-1) begin
            exp_armed = 1'b0;
            exp_addr  = 0;
         end else begin
            exp_addr++;
         end
      end
   endtask

   task automatic strobe(input logic m, input logic [DW-1:0] w, input int low_cyc);
      @(negedge clk);
      mode = m;
      bus  = w;
      wr_n = 1'b0;
      repeat (low_cyc) @(negedge clk);
      wr_n = 1'b1;
      repeat (5) @(negedge clk);
      model(m, w);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int k = 0; k < ND; k++) exp_mem[k] = '0;
      exp_flags = 3'b000;
      exp_armed = 1'b0;
      exp_addr  = 0;

      repeat (4) @(negedge clk);
      chk_all("R1");                  // during reset
      rst = 1'b0;
      repeat (2) @(negedge clk);
      chk_all("R1");                  // after reset

      // R7: unarmed data strobes (also right after reset, R1)
      strobe(1'b0, 4'hA, 3);
      chk_all("R7");

      // R2 / R6: every flag combination without arming
      for (int f = 0; f < 8; f++) begin
         strobe(1'b1, 4'(f), 3);
         chk_all("R2");
         strobe(1'b0, 4'h5, 3);
         chk_all("R6");               // still unarmed, memory untouched
      end

      // R3 / R10: sixteen bursts sweep every value through every digit
      for (int b = 0; b < 16; b++) begin
         strobe(1'b1, 4'(8 | (b % 8)), 3);
         for (int i = 0; i < ND; i++) begin
            strobe(1'b0, 4'((i * 5 + b) & 15), 2 + (i % 3));
            chk_all("R3");
         end
         // R4: locked after the eighth word
         strobe(1'b0, 4'((b + 7) & 15), 3);
         chk_all("R4");
      end

      // R5: re-arm, partial burst, tail keeps old values
      strobe(1'b1, 4'b1001, 3);
      for (int i = 0; i < 3; i++) strobe(1'b0, 4'(12 - i), 3);
      chk_all("R5");

      // R6: mid-burst control word without arm bit: flags change,
      // loader stays armed, writes restart at digit 0
      strobe(1'b1, 4'b0110, 3);
      chk_all("R6");
      strobe(1'b0, 4'hE, 3);
      chk_all("R6");
      chk("R6", "digit0 restart", int'(digits[0 +: DW]), 14);

      // R9: strobe held low for many cycles writes once
      strobe(1'b1, 4'b1000, 3);
      strobe(1'b0, 4'h3, 40);
      chk_all("R9");
      chk("R9", "digit1 untouched", int'(digits[DW +: DW]), int'(exp_mem[1]));

      // R8: latency of exactly three rising edges
      @(negedge clk);
      mode = 1'b0;
      bus  = 4'h9;
      wr_n = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      chk("R8", "digit1 after 2 edges", int'(digits[DW +: DW]), int'(exp_mem[1]));
      @(posedge clk); #1;
      chk("R8", "digit1 after 3 edges", int'(digits[DW +: DW]), 9);
      repeat (3) @(negedge clk);
      wr_n = 1'b1;
      repeat (5) @(negedge clk);
      model(1'b0, 4'h9);
      chk_all("R8");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule